// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block decides when an asynchronous DRAM must receive initialisation and refresh cycles. It asks a separate DRAM controller for them through a request/acknowledge pair. The block itself never drives the memory pins. After reset it keeps the memory idle for a fixed power-up pause. It then asks for a burst of wake-up refreshes, each of which must contain a row strobe. When the burst is complete it reports that the memory is ready for normal access.

In normal operation an interval timer adds one owed refresh per row slot. The slot length is the retention period divided by the row count. The request stays high while any refresh is owed, and each accepted acknowledge pays one off. If the owed count grows to a set limit, retention can no longer be guaranteed. The block then withdraws ready and repeats the whole wake-up burst before it lets access resume.

All timing comes from the clock frequency in MHz: the pause, the retention window, the row count, the burst length and the owed limit.

Top module: `rfs_sched`

## Requirements
- R1: While reset is released and the phase output reads 0 (pause), the request and ready outputs are low. An acknowledge in this phase has no effect. The phase moves to 1 (wake) exactly PAUSE_US*CLK_MHZ rising edges after reset is released.
- R2: While the phase reads 1 (wake), the request is held high and ready is low.
- R3: Each clock edge with both the acknowledge and the request high, during wake, counts one wake-up refresh. The edge that takes the WAKE_CYCLES-th such acknowledge moves the phase to 2 (run) and raises ready.
- R4: In run, a row slot elapses every CLK_MHZ*RETAIN_US/ROWS cycles, with the first slot ending that many edges after run is entered. Each slot end adds one owed refresh.
- R5: In run, the request is high exactly when at least one refresh is owed. An acknowledge taken with the request high removes one owed refresh. An acknowledge while the request is low is ignored, and the count never wraps below zero.
- R6: A slot end and an accepted acknowledge on the same edge leave the owed count unchanged.
- R7: When the owed count reaches OWED_LIMIT in run, the next edge returns the phase to wake with ready low. The owed count is cleared, and a full set of WAKE_CYCLES acknowledges is needed again.
- R8: Ready is high exactly when the phase reads 2 (run).
- R9: The phase output never reads 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_ack | input | 1 | Controller accepts the pending refresh on this edge |
| rfsh_req | output | 1 | A refresh cycle is wanted |
| ready | output | 1 | Memory initialised and in retention; normal access allowed |
| phase | output | 2 | 0 pause, 1 wake, 2 run |

## Verification
The acknowledge input is driven in four patterns:
- Held high through the pause. This shows that the pause length does not depend on the controller.
- Granted on every request cycle. This shows the exact burst length and the slot period.
- Withheld for several slots. This lets the owed count build up to the limit and shows the fall-back to wake and the second burst.
- Forced high while nothing is owed. This separates a correct count from one that wraps below zero.

A two-cycle acknowledge pulse is also placed so that its first cycle lands on a slot end. It tells apart three cases: a correct net-zero update, an update where the acknowledge wins, and an update where the slot end wins.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } rfs_phase_e;

  // Cycles spanned by a time in microseconds at the given clock rate.
  function automatic int us_to_cycles(input int mhz, input int us);
    return mhz * us;
  endfunction

  // Cycles in one row slot: retention window split evenly over the rows.
  function automatic int slot_cycles(input int mhz, input int retain_us, input int rows);
    int c;
    c = (mhz * retain_us) / rows;
    return (c < 2) ? 2 : c;
  endfunction

  // Bits needed to hold values 0..maxval, never fewer than one.
  function automatic int bits_for(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/rfs_span_timer.sv
module rfs_span_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic hold_clr,
  output logic span_end
);
  localparam int CW = rfs_pkg::bits_for(LEN - 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  assign span_end = run_en && !hold_clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || hold_clr) begin
      cnt <= '0;
    end else if (run_en) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R4
  span_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    span_end |=> (cnt == '0));

endmodule

// File: rtl/rfs_owed_ctr.sv
module rfs_owed_ctr #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe,
  input  logic slot_end,
  input  logic paid,
  output logic pending,
  output logic at_limit
);
  localparam int OW = rfs_pkg::bits_for(LIMIT);
  localparam logic [OW-1:0] TOP = OW'(LIMIT);

  logic [OW-1:0] owed;
  logic          add_one;
  logic          sub_one;

  assign add_one  = slot_end && !paid && (owed != TOP);
  assign sub_one  = paid && !slot_end && (owed != '0);
  assign pending  = (owed != '0);
  assign at_limit = (owed == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      owed <= '0;
    end else if (add_one) begin
      owed <= owed + 1'b1;
    end else if (sub_one) begin
      owed <= owed - 1'b1;
    end
  end

  // R6
  tie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && paid && !wipe) |=> (owed == $past(owed)));

  // R5
  pay_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paid && !slot_end && !wipe && pending) |=> (owed == $past(owed - OW'(1))));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= TOP);

endmodule

// File: rtl/rfs_phase_fsm.sv
module rfs_phase_fsm
  import rfs_pkg::*;
#(
  parameter int WAKE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pause_done,
  input  logic       ack,
  input  logic       pending,
  input  logic       overdue,
  output rfs_phase_e state,
  output logic       req,
  output logic       ack_take
);
  localparam int WW = bits_for(WAKE_CYCLES - 1);
  localparam logic [WW-1:0] WLAST = WW'(WAKE_CYCLES - 1);

  logic [WW-1:0] wake_cnt;

  assign req      = (state == PH_WAKE) || ((state == PH_RUN) && pending);
  assign ack_take = ack && req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PH_PAUSE;
      wake_cnt <= '0;
    end else begin
      case (state)
        PH_PAUSE: begin
          wake_cnt <= '0;
          if (pause_done) state <= PH_WAKE;
        end
        PH_WAKE: begin
          if (ack_take) begin
            if (wake_cnt == WLAST) state <= PH_RUN;
            else                   wake_cnt <= wake_cnt + 1'b1;
          end
        end
        PH_RUN: begin
          if (overdue) begin
            state    <= PH_WAKE;
            wake_cnt <= '0;
          end
        end
        default: state <= PH_PAUSE;
      endcase
    end
  end

  // R3
  burst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_WAKE && ack_take && wake_cnt == WLAST) |=> (state == PH_RUN));

  // R3
  burst_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_WAKE && wake_cnt != WLAST) |=> (state == PH_WAKE));

endmodule

// File: rtl/rfs_sched.sv
module rfs_sched
  import rfs_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int PAUSE_US    = 200,
  parameter int RETAIN_US   = 4000,
  parameter int ROWS        = 256,
  parameter int WAKE_CYCLES = 8,
  parameter int OWED_LIMIT  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rfsh_ack,
  output logic       rfsh_req,
  output logic       ready,
  output logic [1:0] phase
);
  localparam int PAUSE_CYC = us_to_cycles(CLK_MHZ, PAUSE_US);
  localparam int SLOT_CYC  = slot_cycles(CLK_MHZ, RETAIN_US, ROWS);

  rfs_phase_e state;
  logic       in_pause;
  logic       in_run;
  logic       pause_done;
  logic       slot_end;
  logic       pending;
  logic       overdue;
  logic       at_limit;
  logic       ack_take;

  assign in_pause = (state == PH_PAUSE);
  assign in_run   = (state == PH_RUN);
  assign overdue  = in_run && at_limit;

  rfs_span_timer #(.LEN(PAUSE_CYC)) u_pause (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (in_pause),
    .hold_clr (!in_pause),
    .span_end (pause_done)
  );

  rfs_span_timer #(.LEN(SLOT_CYC)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (in_run),
    .hold_clr (!in_run),
    .span_end (slot_end)
  );

  rfs_owed_ctr #(.LIMIT(OWED_LIMIT)) u_owed (
    .clk      (clk),
    .rst_n    (rst_n),
    .wipe     (!in_run),
    .slot_end (slot_end),
    .paid     (ack_take && in_run),
    .pending  (pending),
    .at_limit (at_limit)
  );

  rfs_phase_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pause_done (pause_done),
    .ack        (rfsh_ack),
    .pending    (pending),
    .overdue    (overdue),
    .state      (state),
    .req        (rfsh_req),
    .ack_take   (ack_take)
  );

  assign ready = in_run;
  assign phase = state;

  // R1
  quiet_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |-> (!rfsh_req && !ready));

  // R2
  wake_asks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1) |-> (rfsh_req && !ready));

  // R7
  overdue_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && at_limit) |=> (phase == 2'd1 && !ready));

  // R9
  legal_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

endmodule

// File: tb/rfs_sched_test.sv
module rfs_sched_test;

  localparam int MHZ   = 1;
  localparam int P     = 40;       // PAUSE_US at 1 MHz
  localparam int RET   = 256;
  localparam int NROW  = 16;
  localparam int W     = 8;
  localparam int LIM   = 3;
  localparam int I     = (MHZ * RET) / NROW;   // 16-cycle slot

  localparam int T_RUN  = P + W;               // first entry to run
  localparam int T_OVER = T_RUN + 6 * I;       // owed reaches LIM here
  localparam int T_RUN2 = T_OVER + 2 + W;      // second entry to run

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rfsh_ack = 1'b0;
  logic       rfsh_req;
  logic       ready;
  logic [1:0] phase;

  logic auto_ack = 1'b1;
  logic force_ack = 1'b1;
  int   n_edge = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  typedef struct {
    int    at;
    logic  rq;
    logic  rdy;
    logic [1:0] ph;
    string tag;
  } exp_t;

  exp_t sb[$];

  rfs_sched #(
    .CLK_MHZ(MHZ), .PAUSE_US(P), .RETAIN_US(RET), .ROWS(NROW),
    .WAKE_CYCLES(W), .OWED_LIMIT(LIM)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rfsh_ack(rfsh_ack),
    .rfsh_req(rfsh_req), .ready(ready), .phase(phase)
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n) n_edge = n_edge + 1;

  // acknowledge driver: applied mid-cycle, seen at the next edge
  always @(negedge clk) rfsh_ack = force_ack | (auto_ack & rfsh_req);

  task automatic expect_at(input int at, input logic rq, input logic rdy,
                           input logic [1:0] ph, input string tag);
    exp_t e;
    e.at = at; e.rq = rq; e.rdy = rdy; e.ph = ph; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_n(input int k);
    while (n_edge < k) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++; errors++;
        $display("FAIL %s: never sampled at edge %0d (actual none, expected sample)", e.tag, e.at);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: compares outputs against the scoreboard away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      while (sb.size() > 0 && sb[0].at <= n_edge) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (e.at != n_edge) begin
          errors++;
          $display("FAIL %s: stale item at %0d (actual edge %0d, expected edge %0d)",
                   e.tag, e.at, n_edge, e.at);
        end else if (rfsh_req !== e.rq || ready !== e.rdy || phase !== e.ph) begin
          errors++;
          $display("FAIL %s @%0d: actual req=%b rdy=%b ph=%0d expected req=%b rdy=%b ph=%0d",
                   e.tag, n_edge, rfsh_req, ready, phase, e.rq, e.rdy, e.ph);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state and pause length, with a stray acknowledge held high
    expect_at(0,      1'b0, 1'b0, 2'd0, "R1 reset state");
    expect_at(20,     1'b0, 1'b0, 2'd0, "R1 ack ignored in pause");
    expect_at(P - 1,  1'b0, 1'b0, 2'd0, "R1 pause last cycle");
    expect_at(P,      1'b1, 1'b0, 2'd1, "R2 wake entered");
    expect_at(P + W - 1, 1'b1, 1'b0, 2'd1, "R3 burst one short");
    expect_at(T_RUN,  1'b0, 1'b1, 2'd2, "R3 R8 run after burst");
    expect_at(T_RUN + I - 1, 1'b0, 1'b1, 2'd2, "R4 before first slot");
    expect_at(T_RUN + I,     1'b1, 1'b1, 2'd2, "R4 first slot end");
    expect_at(T_RUN + I + 1, 1'b0, 1'b1, 2'd2, "R5 paid off");
    expect_at(T_RUN + 2 * I, 1'b1, 1'b1, 2'd2, "R4 second slot unpaid");
    expect_at(T_RUN + 3 * I, 1'b1, 1'b1, 2'd2, "R6 tie leaves one owed");
    expect_at(T_RUN + 3 * I + 1, 1'b0, 1'b1, 2'd2, "R6 single ack clears");
    expect_at(T_RUN + 4 * I, 1'b1, 1'b1, 2'd2, "R5 owed one");
    expect_at(T_RUN + 5 * I, 1'b1, 1'b1, 2'd2, "R5 owed two");
    expect_at(T_OVER,     1'b1, 1'b1, 2'd2, "R7 limit reached still run");
    expect_at(T_OVER + 1, 1'b1, 1'b0, 2'd1, "R7 back to wake");
    expect_at(T_RUN2 - 1, 1'b1, 1'b0, 2'd1, "R7 full burst needed");
    expect_at(T_RUN2,     1'b0, 1'b1, 2'd2, "R7 R8 run again");
    expect_at(T_RUN2 + I - 1, 1'b0, 1'b1, 2'd2, "R7 owed cleared");
    expect_at(T_RUN2 + I,     1'b1, 1'b1, 2'd2, "R4 slot after rewake");
    expect_at(T_RUN2 + I + 1, 1'b0, 1'b1, 2'd2, "R5 paid after rewake");
    expect_at(T_RUN2 + I + 5, 1'b0, 1'b1, 2'd2, "R5 no underflow");
    expect_at(T_RUN2 + 2 * I, 1'b1, 1'b1, 2'd2, "R5 slot with stray acks");
    expect_at(T_RUN2 + 2 * I + 1, 1'b0, 1'b1, 2'd2, "R5 stray ack pays once");
    expect_at(T_RUN2 + 2 * I + 14, 1'b0, 1'b1, 2'd2, "R9 steady run");

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    wait_n(30);         force_ack = 1'b0;
    wait_n(T_RUN + I + 2); auto_ack = 1'b0;
    wait_n(T_RUN + 3 * I - 1); force_ack = 1'b1;   // acks land on slot edge and next
    wait_n(T_RUN + 3 * I + 1); force_ack = 1'b0;
    wait_n(T_OVER + 2); auto_ack = 1'b1;
    wait_n(T_RUN2 + I + 2); force_ack = 1'b1;      // acks while nothing owed
    wait_n(T_RUN2 + 2 * I + 14); force_ack = 1'b0;
    wait_n(T_RUN2 + 2 * I + 16);
    finish_run();
  end

endmodule